// File: doc/BRIEF.md
# Physical Register Rename Unit

This block maps architectural register names onto one shared pool of physical registers. Committed values and speculative values both live in that pool. Each cycle it can rename a bundle of up to `LANES` instructions. Every source is translated through a speculative map table. Every instruction that writes a register is given a fresh physical register taken from a free list. The previous mapping of that destination is reported alongside it. Renaming removes write-after-write and write-after-read hazards, so only true data dependences remain. Dependences between instructions of the same bundle are resolved in the same cycle, in lane order.

Each renamed instruction enters an in-order queue. A commit port retires up to `LANES` of the oldest entries per cycle. A retiring entry makes its mapping non-speculative in a committed map table. It also returns the physical register that held the older value of that destination. A recovery input discards all speculative work. It copies the committed map into the speculative map, rebuilds the free list from committed state and empties the queue. The default sizes are 32 architectural registers, 64 physical registers, a 64-entry queue and two lanes.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and physical registers 32 to 63 are free. The first register allocated is 32.
- R2: A source operand gets the physical register currently held in the speculative map for it. Architectural register 0 always gives physical register 0.
- R3: Each lane that has a valid, non-zero destination gets the lowest-numbered free physical register. An earlier lane gets a lower number than a later lane. `ren_pold` reports the mapping the destination had before the bundle.
- R4: When a later lane reads a register that an earlier lane of the same bundle writes, its source is the earlier lane's new physical register.
- R5: When two lanes of a bundle write the same register, the later lane's `ren_pold` is the earlier lane's new register, and the map keeps the later lane's register.
- R6: A lane whose destination is register 0 reports 0 on both `ren_pdst` and `ren_pold`, and it uses no free register.
- R7: `ren_ready` is low whenever the free registers number fewer than the lanes that need a destination, or whenever the queue has fewer free slots than valid lanes. A bundle is accepted whole or not at all, and a refused bundle changes no state.
- R8: `cmt_num` retires that many of the oldest queue entries, in order (clipped to the occupancy). Each retired entry with a non-zero destination frees its old register. That register becomes allocatable from the next cycle, not in the commit cycle.
- R9: While `recover` is high, `ren_ready` is low. On that edge, the speculative map becomes the committed map, including the commits of the same cycle. The free list becomes every register absent from the committed map, and the queue becomes empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | LANES | Lane holds an instruction |
| ren_src_a | input | LANES x 5 | First source register per lane |
| ren_src_b | input | LANES x 5 | Second source register per lane |
| ren_dst | input | LANES x 5 | Destination register per lane (0 = none) |
| cmt_num | input | 2 | Number of oldest entries to retire |
| recover | input | 1 | Discard speculative state |
| ren_ready | output | 1 | Bundle accepted this cycle when any lane is valid |
| ren_psrc_a | output | LANES x 6 | Physical first source per lane |
| ren_psrc_b | output | LANES x 6 | Physical second source per lane |
| ren_pdst | output | LANES x 6 | Newly allocated physical destination per lane |
| ren_pold | output | LANES x 6 | Previous mapping of the destination per lane |

## Verification
Three pairs of functions can fall in the same cycle. Rename and commit share a cycle, and so do commit and recovery, and rename and recovery. The bench provokes the first pair by draining the free list completely and then presenting a bundle in the cycle that retires an entry. The bundle must be refused there, and the freed register must be handed out in the following cycle. A recovery combined with a two-entry commit is judged by the sources of the next bundle, which must come from a committed map that already includes both commits. The same pairings also occur in a long random mix, where a behavioural model of maps, free set and queue is compared against every output on every cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int ARCH_REGS = 32;
    localparam int PHYS_REGS = 64;
    localparam int LANES     = 2;
    localparam int QDEPTH    = 64;   // power of two

    localparam int AW  = $clog2(ARCH_REGS);
    localparam int PW  = $clog2(PHYS_REGS);
    localparam int QW  = $clog2(QDEPTH);
    localparam int QCW = $clog2(QDEPTH + 1);
    localparam int CW  = $clog2(LANES + 1);

    typedef logic [AW-1:0]                   arch_t;
    typedef logic [PW-1:0]                   phys_t;
    typedef logic [PHYS_REGS-1:0]            pvec_t;
    typedef logic [ARCH_REGS-1:0][PW-1:0]    map_t;

    typedef struct packed {
        arch_t arch;
        phys_t pnew;
        phys_t pold;
    } qent_t;

    function automatic map_t identity_map();
        map_t m;
        for (int i = 0; i < ARCH_REGS; i++) m[i] = phys_t'(i);
        return m;
    endfunction

    function automatic pvec_t boot_free();
        pvec_t v;
        for (int i = 0; i < PHYS_REGS; i++) v[i] = (i >= ARCH_REGS);
        return v;
    endfunction
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist import rn_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic [LANES-1:0]    need,
    input  logic                take,
    input  pvec_t               rel_vec,
    input  logic                restore,
    input  pvec_t               restore_vec,
    output phys_t [LANES-1:0]   grant,
    output logic                enough
);
    pvec_t free_q;
    pvec_t pick_mask;
    pvec_t scan;

    // Lowest free register per needing lane, lanes served in order.
    always_comb begin
        scan      = free_q;
        pick_mask = '0;
        grant     = '0;
        for (int k = 0; k < LANES; k++) begin
            if (need[k]) begin
                for (int j = PHYS_REGS - 1; j >= 0; j--) begin
                    if (scan[j]) grant[k] = phys_t'(j);
                end
                if (scan != '0) begin
                    scan[grant[k]]      = 1'b0;
                    pick_mask[grant[k]] = 1'b1;
                end
            end
        end
    end

    assign enough = ($countones(free_q) >= $countones(need));

    always_ff @(posedge clk) begin
        if (rst)
            free_q <= boot_free();
        else if (restore)
            free_q <= restore_vec;
        else
            free_q <= (free_q & ~(take ? pick_mask : '0)) | rel_vec;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_grant_chk
        // R3: a granted register was free and is never register 0
        a_r3_grant_was_free: assert property (@(posedge clk) disable iff (rst)
            (take && need[k]) |-> (free_q[grant[k]] && grant[k] != '0));
    end

    // R8: a released register was in use
    a_r8_release_in_use: assert property (@(posedge clk) disable iff (rst)
        !restore |-> ((rel_vec & free_q) == '0));
endmodule

// File: rtl/rn_specmap.sv
module rn_specmap import rn_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic [LANES-1:0]    wr_en,
    input  arch_t [LANES-1:0]   wr_arch,
    input  phys_t [LANES-1:0]   wr_phys,
    input  logic                restore,
    input  map_t                restore_map,
    output map_t                map_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= identity_map();
        end else if (restore) begin
            map_q <= restore_map;
        end else begin
            // later lanes override earlier ones on the same register
            for (int k = 0; k < LANES; k++) begin
                if (wr_en[k]) map_q[wr_arch[k]] <= wr_phys[k];
            end
        end
    end

    // R6: register 0 stays pinned to physical 0
    a_r6_zero_pinned: assert property (@(posedge clk) disable iff (rst)
        map_q[0] == '0);

    for (genvar k = 0; k < LANES; k++) begin : g_wr_chk
        // R6: no lane ever remaps register 0
        a_r6_no_zero_write: assert property (@(posedge clk) disable iff (rst)
            wr_en[k] |-> (wr_arch[k] != '0));
    end
endmodule

// File: rtl/rn_commitq.sv
module rn_commitq import rn_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic [LANES-1:0]    enq_en,
    input  qent_t [LANES-1:0]   enq_ent,
    input  logic [CW-1:0]       cmt_num,
    input  logic                flush,
    output logic [QCW-1:0]      space,
    output map_t                cmap_next,
    output pvec_t               cfree_next,
    output pvec_t               rel_vec
);
    qent_t              ring [QDEPTH];
    logic [QW-1:0]      head_q, tail_q;
    logic [QCW-1:0]     cnt_q;
    map_t               cmap_q;
    pvec_t              cfree_q;
    logic [QCW-1:0]     ncmt;
    logic [QCW-1:0]     enq_total;
    logic [QW-1:0]      enq_slot [LANES];
    qent_t              head_ent;

    assign ncmt  = (QCW'(cmt_num) > cnt_q) ? cnt_q : QCW'(cmt_num);
    assign space = QCW'(QDEPTH) - cnt_q;

    // Retire the oldest entries in order, updating the committed view.
    always_comb begin
        cmap_next  = cmap_q;
        cfree_next = cfree_q;
        rel_vec    = '0;
        head_ent   = '0;
        for (int k = 0; k < LANES; k++) begin
            if (QCW'(k) < ncmt) begin
                head_ent = ring[head_q + QW'(k)];
                if (head_ent.arch != '0) begin
                    cmap_next[head_ent.arch]  = head_ent.pnew;
                    cfree_next[head_ent.pnew] = 1'b0;
                    cfree_next[head_ent.pold] = 1'b1;
                    rel_vec[head_ent.pold]    = 1'b1;
                end
            end
        end
    end

    // Compact valid lanes onto consecutive slots.
    always_comb begin
        enq_total = '0;
        for (int k = 0; k < LANES; k++) begin
            enq_slot[k] = tail_q + QW'(enq_total);
            enq_total   = enq_total + QCW'(enq_en[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            cnt_q   <= '0;
            cmap_q  <= identity_map();
            cfree_q <= boot_free();
        end else begin
            cmap_q  <= cmap_next;
            cfree_q <= cfree_next;
            if (flush) begin
                head_q <= '0;
                tail_q <= '0;
                cnt_q  <= '0;
            end else begin
                head_q <= head_q + QW'(ncmt);
                tail_q <= tail_q + QW'(enq_total);
                cnt_q  <= cnt_q - ncmt + enq_total;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (enq_en[k] && !flush) ring[enq_slot[k]] <= enq_ent[k];
        end
    end

    // R9: recovery leaves the queue empty
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt_q == '0));

    // R7: occupancy never exceeds the depth
    a_r7_queue_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= QCW'(QDEPTH));

    // R7: an accepted bundle always fits
    a_r7_enq_fits: assert property (@(posedge clk) disable iff (rst)
        (|enq_en) |-> (enq_total <= space));
endmodule

// File: rtl/rename_unit.sv
module rename_unit import rn_pkg::*; (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            ren_valid,
    input  logic [LANES-1:0][AW-1:0]    ren_src_a,
    input  logic [LANES-1:0][AW-1:0]    ren_src_b,
    input  logic [LANES-1:0][AW-1:0]    ren_dst,
    input  logic [CW-1:0]               cmt_num,
    input  logic                        recover,
    output logic                        ren_ready,
    output logic [LANES-1:0][PW-1:0]    ren_psrc_a,
    output logic [LANES-1:0][PW-1:0]    ren_psrc_b,
    output logic [LANES-1:0][PW-1:0]    ren_pdst,
    output logic [LANES-1:0][PW-1:0]    ren_pold
);
    logic [LANES-1:0]   need;
    logic               fire;
    logic               enough;
    logic [QCW-1:0]     space;
    phys_t [LANES-1:0]  grant;
    map_t               smap;
    map_t               cmap_next;
    pvec_t              cfree_next;
    pvec_t              rel_vec;
    logic [LANES-1:0]   enq_en;
    qent_t [LANES-1:0]  enq_ent;
    logic [LANES-1:0]   map_wr;
    arch_t [LANES-1:0]  map_arch;

    always_comb begin
        for (int k = 0; k < LANES; k++)
            need[k] = ren_valid[k] && (ren_dst[k] != '0);
    end

    assign ren_ready = !recover && enough &&
                       (int'(space) >= $countones(ren_valid));
    assign fire      = ren_ready && (|ren_valid);

    // Bundle resolution: map lookup, then overrides from earlier lanes.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            ren_psrc_a[k] = smap[ren_src_a[k]];
            ren_psrc_b[k] = smap[ren_src_b[k]];
            ren_pdst[k]   = need[k] ? grant[k] : '0;
            ren_pold[k]   = need[k] ? smap[ren_dst[k]] : '0;
            for (int j = 0; j < k; j++) begin
                if (need[j] && ren_src_a[k] == ren_dst[j]) ren_psrc_a[k] = grant[j];
                if (need[j] && ren_src_b[k] == ren_dst[j]) ren_psrc_b[k] = grant[j];
                if (need[j] && need[k] && ren_dst[k] == ren_dst[j]) ren_pold[k] = grant[j];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            enq_en[k]       = fire && ren_valid[k];
            enq_ent[k].arch = need[k] ? ren_dst[k] : '0;
            enq_ent[k].pnew = ren_pdst[k];
            enq_ent[k].pold = ren_pold[k];
            map_wr[k]       = fire && need[k];
            map_arch[k]     = ren_dst[k];
        end
    end

    rn_freelist u_free (
        .clk         (clk),
        .rst         (rst),
        .need        (need),
        .take        (fire),
        .rel_vec     (rel_vec),
        .restore     (recover),
        .restore_vec (cfree_next),
        .grant       (grant),
        .enough      (enough)
    );

    rn_specmap u_map (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (map_wr),
        .wr_arch     (map_arch),
        .wr_phys     (grant),
        .restore     (recover),
        .restore_map (cmap_next),
        .map_q       (smap)
    );

    rn_commitq u_queue (
        .clk        (clk),
        .rst        (rst),
        .enq_en     (enq_en),
        .enq_ent    (enq_ent),
        .cmt_num    (cmt_num),
        .flush      (recover),
        .space      (space),
        .cmap_next  (cmap_next),
        .cfree_next (cfree_next),
        .rel_vec    (rel_vec)
    );

    for (genvar k = 1; k < LANES; k++) begin : g_lane_chk
        // R4: neighbouring lane read-after-write inside a bundle
        a_r4_bypass_src: assert property (@(posedge clk) disable iff (rst)
            (fire && need[k-1] && ren_valid[k] && ren_src_a[k] == ren_dst[k-1])
            |-> (ren_psrc_a[k] == ren_pdst[k-1]));
        // R5: same destination in neighbouring lanes chains the old mapping
        a_r5_chain_old: assert property (@(posedge clk) disable iff (rst)
            (fire && need[k-1] && need[k] && ren_dst[k] == ren_dst[k-1])
            |-> (ren_pold[k] == ren_pdst[k-1]));
        // R3: two allocations in one bundle differ
        a_r3_distinct: assert property (@(posedge clk) disable iff (rst)
            (fire && need[k-1] && need[k]) |-> (ren_pdst[k] != ren_pdst[k-1]));
    end
endmodule

// File: tb/sim_rename_unit.sv
`timescale 1ns/1ps
module sim_rename_unit;
    import rn_pkg::*;

    localparam real HALF = 10.0;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [LANES-1:0]           ren_valid = '0;
    logic [LANES-1:0][AW-1:0]   ren_src_a = '0;
    logic [LANES-1:0][AW-1:0]   ren_src_b = '0;
    logic [LANES-1:0][AW-1:0]   ren_dst   = '0;
    logic [CW-1:0]              cmt_num   = '0;
    logic                       recover   = 1'b0;
    logic                       ren_ready;
    logic [LANES-1:0][PW-1:0]   ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;

    rename_unit u0 (.*);

    always #HALF clk = ~clk;

    typedef struct { int a; int n; int o; } ment_t;

    int     total = 0;
    int     bad   = 0;
    int     smap [ARCH_REGS];
    int     cmap [ARCH_REGS];
    bit     freev [PHYS_REGS];
    ment_t  q [$];

    bit     t_v  [LANES];
    int     t_sa [LANES];
    int     t_sb [LANES];
    int     t_d  [LANES];
    int     t_cn;
    bit     t_rec;
    string  t_note = "";

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, t_note, act, exp);
        end
    endtask

    task automatic clear_in();
        for (int k = 0; k < LANES; k++) begin
            t_v[k] = 0; t_sa[k] = 0; t_sb[k] = 0; t_d[k] = 0;
        end
        t_cn = 0; t_rec = 0;
    endtask

    task automatic lane(int k, int sa, int sb, int d);
        t_v[k] = 1; t_sa[k] = sa; t_sb[k] = sb; t_d[k] = d;
    endtask

    task automatic step();
        int nv, nd, nfree, cnum, pick;
        bit expr;
        int tmap [ARCH_REGS];
        bit tfree [PHYS_REGS];
        int inb [ARCH_REGS];
        ment_t pend [$];
        ment_t e;
        @(negedge clk);
        for (int k = 0; k < LANES; k++) begin
            ren_valid[k] = t_v[k];
            ren_src_a[k] = AW'(t_sa[k]);
            ren_src_b[k] = AW'(t_sb[k]);
            ren_dst[k]   = AW'(t_d[k]);
        end
        cmt_num = CW'(t_cn);
        recover = t_rec;
        #2;
        nv = 0; nd = 0; nfree = 0;
        for (int k = 0; k < LANES; k++) if (t_v[k]) begin
            nv++;
            if (t_d[k] != 0) nd++;
        end
        for (int p = 0; p < PHYS_REGS; p++) if (freev[p]) nfree++;
        expr = !t_rec && nfree >= nd && (QDEPTH - q.size()) >= nv;
        chk(ren_ready === expr, t_rec ? "R9 ready" : "R7 ready", int'(ren_ready), int'(expr));
        tmap  = smap;
        tfree = freev;
        for (int a = 0; a < ARCH_REGS; a++) inb[a] = -1;
        if (expr && nv > 0) begin
            for (int k = 0; k < LANES; k++) if (t_v[k]) begin
                chk(int'(ren_psrc_a[k]) == tmap[t_sa[k]], inb[t_sa[k]] >= 0 ? "R4 src_a" : "R2 src_a",
                    int'(ren_psrc_a[k]), tmap[t_sa[k]]);
                chk(int'(ren_psrc_b[k]) == tmap[t_sb[k]], inb[t_sb[k]] >= 0 ? "R4 src_b" : "R2 src_b",
                    int'(ren_psrc_b[k]), tmap[t_sb[k]]);
                if (t_d[k] != 0) begin
                    pick = -1;
                    for (int p = PHYS_REGS - 1; p >= 0; p--) if (tfree[p]) pick = p;
                    chk(int'(ren_pdst[k]) == pick, "R3 pdst", int'(ren_pdst[k]), pick);
                    chk(int'(ren_pold[k]) == tmap[t_d[k]], inb[t_d[k]] >= 0 ? "R5 pold" : "R3 pold",
                        int'(ren_pold[k]), tmap[t_d[k]]);
                    e.a = t_d[k]; e.n = pick; e.o = tmap[t_d[k]];
                    tmap[t_d[k]] = pick;
                    tfree[pick]  = 0;
                    inb[t_d[k]]  = k;
                end else begin
                    chk(ren_pdst[k] == '0, "R6 pdst", int'(ren_pdst[k]), 0);
                    chk(ren_pold[k] == '0, "R6 pold", int'(ren_pold[k]), 0);
                    e.a = 0; e.n = 0; e.o = 0;
                end
                pend.push_back(e);
            end
            smap  = tmap;
            freev = tfree;
        end
        cnum = (t_cn < q.size()) ? t_cn : q.size();
        for (int i = 0; i < cnum; i++) begin
            e = q.pop_front();
            if (e.a != 0) begin
                cmap[e.a]  = e.n;
                freev[e.o] = 1;
            end
        end
        if (t_rec) begin
            smap = cmap;
            for (int p = 0; p < PHYS_REGS; p++) freev[p] = 1;
            for (int a = 0; a < ARCH_REGS; a++) freev[cmap[a]] = 0;
            q.delete();
        end else begin
            foreach (pend[i]) q.push_back(pend[i]);
        end
    endtask

    initial begin
        #(2.0 * HALF * 200000.0);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < ARCH_REGS; a++) begin smap[a] = a; cmap[a] = a; end
        for (int p = 0; p < PHYS_REGS; p++) freev[p] = (p >= ARCH_REGS);
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, first allocation is 32
        t_note = "R1";
        clear_in(); step();
        clear_in(); lane(0, 1, 2, 5); step();
        chk(int'(ren_pdst[0]) == ARCH_REGS, "R1 first alloc", int'(ren_pdst[0]), ARCH_REGS);

        // R4 / R5: in-bundle read-after-write and write-after-write
        t_note = "R4 R5";
        clear_in(); lane(0, 5, 4, 3); lane(1, 3, 5, 3); step();
        clear_in(); lane(0, 3, 0, 6); lane(1, 6, 6, 7); step();

        // R6: destination zero consumes nothing
        t_note = "R6";
        clear_in(); lane(0, 3, 7, 0); lane(1, 0, 6, 0); step();
        clear_in(); lane(0, 0, 0, 9); step();

        // R7: drain the free list, all-or-nothing refusal
        t_note = "R7 free";
        for (int i = 0; i < 18; i++) begin
            clear_in(); lane(0, i % 32, 3, (i % 31) + 1); lane(1, 5, (i % 31) + 1, ((i + 7) % 31) + 1); step();
        end
        clear_in(); lane(0, 2, 3, 8); step();
        clear_in(); lane(0, 2, 3, 8); step();

        // R8: commit and rename in the same cycle, reuse next cycle
        t_note = "R8";
        clear_in(); lane(0, 1, 1, 4); lane(1, 2, 2, 4); t_cn = 1; step();
        clear_in(); lane(0, 4, 5, 10); step();
        clear_in(); t_cn = 2; step();
        clear_in(); lane(0, 1, 2, 11); lane(1, 11, 3, 12); step();

        // R9: recovery together with commits
        t_note = "R9";
        clear_in(); lane(0, 3, 5, 6); lane(1, 6, 7, 3); t_cn = 2; t_rec = 1; step();
        clear_in(); lane(0, 3, 5, 6); lane(1, 7, 9, 13); step();
        clear_in(); lane(0, 6, 13, 14); step();

        // R7: queue-limited refusal with zero destinations
        t_note = "R7 queue";
        for (int i = 0; i < 34; i++) begin
            clear_in(); lane(0, i % 32, 1, 0); lane(1, 2, i % 32, 0); step();
        end
        clear_in(); t_rec = 1; step();

        // mixed random traffic
        t_note = "mix R2 R3 R8 R9";
        for (int i = 0; i < 3000; i++) begin
            clear_in();
            for (int k = 0; k < LANES; k++) begin
                if ($urandom_range(0, 3) != 0)
                    lane(k, $urandom_range(0, 31), $urandom_range(0, 31),
                         ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 31));
            end
            t_cn  = $urandom_range(0, LANES);
            t_rec = ($urandom_range(0, 63) == 0);
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule